// File: doc/BRIEF.md
# Buffer-ID Queue Bank

The block holds a set of independent first-in first-out queues of buffer identifiers, shared between a host processor and the packet and TDM datapath engines. Each identifier is 13 bits wide and names a 2 KB-aligned buffer in a 24-bit external memory space: the identifier supplies address bits [23:11]. Eight queues are built in. Four are filled by the host and drained by hardware: the free pool for TDM receive, the host-to-Ethernet work queue, the free pool for Ethernet receive and the host-to-TDM work queue. The other four are filled by hardware and drained by the host: the TDM-to-host queue, the Ethernet-to-host queue, and the transmit-return and receive-return queues.

The host reaches every queue through one register window. A write to a queue's data register pushes an identifier, a read pops one, and each queue also has a read-only fill level and a writable threshold. When a queue's fill level is above its threshold a sticky status bit is latched. The status bits drive one registered interrupt output, and each bit has a mask. A host bus of 32 or 16 bits is chosen by parameter, and the two widths place the registers at different byte offsets.

Top module: `bidq_bank`

## Requirements
- R1: A host write to the data register (byte offset 16*q + 0) of a host-filled queue pushes `bus_wdata[12:0]`, and the upper write bits are ignored. Host-filled queues are q = 0, 2, 3, 5. The hardware side of such a queue shows the oldest identifier on `hw_pop_id[13*q +: 13]` with `hw_avail[q]` high, and consumes it on `hw_pop_req[q]`.
- R2: A hardware push (`hw_push_valid[q]`) into a hardware-filled queue (q = 1, 4, 6, 7) stores the identifier. A host read of that queue's data register pops the entries in arrival order. The identifier appears in `bus_rdata[12:0]`, with the upper bits zero and `bus_rvalid` high, one cycle after the read is presented.
- R3: The level register (offset 16*q + 4) reads the current number of entries, 0 to DEPTH. It rises by one per accepted push and falls by one per accepted pop.
- R4: A pop from an empty queue returns 0 and leaves the level at 0. `hw_avail[q]` is low while queue q is empty.
- R5: A push into a full queue (DEPTH entries) is dropped, and the stored contents and level are unchanged. The push sets sticky overflow bit q in the overflow register (offset 0x88), and writing a one to that bit clears it.
- R6: The threshold register is at offset 16*q + 8 and resets to DEPTH. One cycle after a queue's level is greater than its threshold, bit q of the status register (offset 0x80) is set. The bit stays set after the level falls.
- R7: Writing a one to a status bit clears it on that edge. If the level is still above the threshold, the bit is set again on the following edge.
- R8: `irq` is a register that takes the OR over all queues of status AND NOT mask, one cycle after the status change. The mask register is at offset 0x84, with bit q masking queue q, and resets to zero.
- R9: With a 32-bit bus, registers respond only when `bus_addr[1:0]` = 00. With a 16-bit bus, they respond only when it is 10. An access with other low bits writes nothing and reads 0, and offsets with bits [3:2] = 11 are unused and also read 0.
- R10: Access against a queue's direction has no effect. A host write to the data register of a hardware-filled queue is ignored, a host read of the data register of a hardware-drained queue returns 0 without popping, and `hw_push_valid` on a host-filled queue is ignored.
- R11: After reset, every level, status, overflow and mask bit is zero, every threshold reads DEPTH, and `irq`, `bus_rvalid` and `hw_avail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | BUS_W | Host write data |
| bus_rdata | output | BUS_W | Host read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| hw_push_valid | input | 8 | Per-queue hardware push strobe |
| hw_push_id | input | 104 | Per-queue 13-bit identifier to push |
| hw_pop_req | input | 8 | Per-queue hardware pop strobe |
| hw_avail | output | 8 | Queue holds an entry for hardware |
| hw_pop_id | output | 104 | Per-queue oldest identifier for hardware |
| irq | output | 1 | Registered interrupt |

## Verification
A host access presented at one edge changes the queue contents and level at that edge. Its read data and `bus_rvalid` are visible after the same edge, a status bit follows one edge later, and `irq` one edge after the status bit. Hardware pops and pushes take effect on the edge at which they are presented. The bench drives inputs on falling edges and samples on the falling edge that follows each register stage it expects. The interrupt checks step through falling edges one at a time, so a status set, a clear and a re-set are each seen on their own cycle rather than at some later point.

// File: rtl/bidq_pkg.sv
// Shared constants and types for the buffer-ID queue bank.
// Assumes at most 8 queues so that the control window sits at bit 7.
package bidq_pkg;
    localparam int ID_W   = 13;
    localparam int NUM_Q  = 8;
    localparam int QSEL_W = $clog2(NUM_Q);
    localparam int ADDR_W = QSEL_W + 5;

    // Queue indices: direction defaults below depend on this order.
    typedef enum logic [QSEL_W-1:0] {
        Q_TDM_FREE   = 3'd0,
        Q_TDM_TO_CPU = 3'd1,
        Q_CPU_TO_ETH = 3'd2,
        Q_ETH_FREE   = 3'd3,
        Q_ETH_TO_CPU = 3'd4,
        Q_CPU_TO_TDM = 3'd5,
        Q_TX_RETURN  = 3'd6,
        Q_RX_RETURN  = 3'd7
    } queue_e;

    localparam logic [NUM_Q-1:0] HOST_FILL_DEF  = 8'b0010_1101;
    localparam logic [NUM_Q-1:0] HOST_DRAIN_DEF = 8'b1101_0010;

    // Per-queue register select (bus_addr[3:2]).
    localparam logic [1:0] QR_DATA   = 2'd0;
    localparam logic [1:0] QR_LEVEL  = 2'd1;
    localparam logic [1:0] QR_THRESH = 2'd2;
    // Control register select (bus_addr[3:2] with bus_addr[7] set).
    localparam logic [1:0] CR_STATUS = 2'd0;
    localparam logic [1:0] CR_MASK   = 2'd1;
    localparam logic [1:0] CR_OVF    = 2'd2;

    typedef struct packed {
        logic              hit;
        logic              ctl;
        logic [QSEL_W-1:0] q;
        logic [1:0]        r;
    } dec_t;
endpackage

// File: rtl/bidq_fifo.sv
// One identifier queue: circular storage with a level counter one bit
// wider than the pointers so a full queue is distinct from an empty one.
// Assumes push and pop are single-cycle strobes; a push when full is
// dropped even if a pop happens in the same cycle.
module bidq_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 13,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_id,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign drop    = push & full;
    assign head    = mem[rp];

    // Storage write; contents need no reset because level guards reads.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_id;
    end

    // Pointer and level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/bidq_decode.sv
// Address decode of the host window. Accepts only the low address bits
// that match the bus width and rejects the unused register slot.
module bidq_decode
    import bidq_pkg::*;
#(
    parameter logic [1:0] LOW_BITS = 2'b00
) (
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output dec_t              dec
);
    // Split the address into window, queue and register fields.
    always_comb begin
        dec.ctl = bus_addr[ADDR_W-1];
        dec.q   = bus_addr[QSEL_W+3:4];
        dec.r   = bus_addr[3:2];
        dec.hit = bus_en && (bus_addr[1:0] == LOW_BITS) && (bus_addr[3:2] != 2'b11)
                  && !(dec.ctl && (dec.q != '0));
    end
endmodule

// File: rtl/bidq_irq.sv
// Sticky status and overflow bits, interrupt mask and registered interrupt.
// Status clear wins over set in the same cycle; overflow set wins over clear.
module bidq_irq #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] above,
    input  logic [NQ-1:0] drop,
    input  logic [NQ-1:0] st_clr,
    input  logic [NQ-1:0] ov_clr,
    input  logic          mask_we,
    input  logic [NQ-1:0] mask_d,
    output logic [NQ-1:0] status,
    output logic [NQ-1:0] ovf,
    output logic [NQ-1:0] mask,
    output logic          irq
);
    // Latch threshold crossings and dropped pushes, apply host clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            ovf    <= '0;
        end else begin
            status <= (status | above) & ~st_clr;
            ovf    <= (ovf & ~ov_clr) | drop;
        end
    end

    // Mask register and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            if (mask_we) mask <= mask_d;
            irq <= |(status & ~mask);
        end
    end
endmodule

// File: rtl/bidq_bank.sv
// Bank of buffer-identifier queues behind one host register window.
// Each queue is filled by either the host or hardware and drained by
// the other, as chosen by HOST_FILL / HOST_DRAIN. Host reads return
// data one cycle after the access. Assumes BUS_W is 16 or 32.
module bidq_bank
    import bidq_pkg::*;
#(
    parameter int               DEPTH      = 64,
    parameter int               BUS_W      = 32,
    parameter logic [NUM_Q-1:0] HOST_FILL  = HOST_FILL_DEF,
    parameter logic [NUM_Q-1:0] HOST_DRAIN = HOST_DRAIN_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_en,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NUM_Q-1:0]       hw_push_valid,
    input  logic [NUM_Q*ID_W-1:0]  hw_push_id,
    input  logic [NUM_Q-1:0]       hw_pop_req,
    output logic [NUM_Q-1:0]       hw_avail,
    output logic [NUM_Q*ID_W-1:0]  hw_pop_id,
    output logic                   irq
);
    localparam int         AW       = $clog2(DEPTH);
    localparam int         LW       = AW + 1;
    localparam logic [1:0] LOW_BITS = (BUS_W == 16) ? 2'b10 : 2'b00;

    dec_t                          dec;
    logic                          wr, rd, ctl_wr;
    logic [NUM_Q-1:0]              q_push, q_pop, q_empty, q_drop, above;
    logic [NUM_Q-1:0]              data_wr, data_rd, thr_wr;
    logic [NUM_Q-1:0][ID_W-1:0]    q_push_id, q_head;
    logic [NUM_Q-1:0][LW-1:0]      lvl, thr;
    logic [NUM_Q-1:0]              status, ovf, mask, st_clr, ov_clr;
    logic                          mask_we;
    logic [BUS_W-1:0]              rd_val;

    bidq_decode #(.LOW_BITS(LOW_BITS)) i_decode (
        .bus_en   (bus_en),
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    assign wr     = dec.hit & bus_we;
    assign rd     = dec.hit & ~bus_we;
    assign ctl_wr = wr & dec.ctl;

    // Per-queue strobes, source selection, storage and threshold.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        assign data_wr[g] = wr & ~dec.ctl & (dec.q == QSEL_W'(g)) & (dec.r == QR_DATA);
        assign data_rd[g] = rd & ~dec.ctl & (dec.q == QSEL_W'(g)) & (dec.r == QR_DATA);
        assign thr_wr[g]  = wr & ~dec.ctl & (dec.q == QSEL_W'(g)) & (dec.r == QR_THRESH);

        if (HOST_FILL[g]) begin : g_host_fill
            assign q_push[g]    = data_wr[g];
            assign q_push_id[g] = bus_wdata[ID_W-1:0];
        end else begin : g_hw_fill
            assign q_push[g]    = hw_push_valid[g];
            assign q_push_id[g] = hw_push_id[g*ID_W +: ID_W];
        end

        if (HOST_DRAIN[g]) begin : g_host_drain
            assign q_pop[g]    = data_rd[g];
            assign hw_avail[g] = 1'b0;
        end else begin : g_hw_drain
            assign q_pop[g]    = hw_pop_req[g];
            assign hw_avail[g] = ~q_empty[g];
        end
        assign hw_pop_id[g*ID_W +: ID_W] = hw_avail[g] ? q_head[g] : '0;

        bidq_fifo #(.DEPTH(DEPTH), .W(ID_W)) i_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (q_push[g]),
            .push_id (q_push_id[g]),
            .pop     (q_pop[g]),
            .head    (q_head[g]),
            .level   (lvl[g]),
            .empty   (q_empty[g]),
            .drop    (q_drop[g])
        );

        // Threshold register for this queue.
        always_ff @(posedge clk) begin
            if (!rst_n)         thr[g] <= LW'(DEPTH);
            else if (thr_wr[g]) thr[g] <= bus_wdata[LW-1:0];
        end

        assign above[g] = lvl[g] > thr[g];
    end

    assign st_clr  = (ctl_wr && dec.r == CR_STATUS) ? bus_wdata[NUM_Q-1:0] : '0;
    assign ov_clr  = (ctl_wr && dec.r == CR_OVF)    ? bus_wdata[NUM_Q-1:0] : '0;
    assign mask_we = ctl_wr && (dec.r == CR_MASK);

    bidq_irq #(.NQ(NUM_Q)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .above   (above),
        .drop    (q_drop),
        .st_clr  (st_clr),
        .ov_clr  (ov_clr),
        .mask_we (mask_we),
        .mask_d  (bus_wdata[NUM_Q-1:0]),
        .status  (status),
        .ovf     (ovf),
        .mask    (mask),
        .irq     (irq)
    );

    // Select the value a host read returns.
    always_comb begin
        rd_val = '0;
        if (dec.ctl) begin
            case (dec.r)
                CR_STATUS: rd_val = BUS_W'(status);
                CR_MASK:   rd_val = BUS_W'(mask);
                CR_OVF:    rd_val = BUS_W'(ovf);
                default:   rd_val = '0;
            endcase
        end else begin
            case (dec.r)
                QR_DATA:   rd_val = (HOST_DRAIN[dec.q] && !q_empty[dec.q]) ? BUS_W'(q_head[dec.q]) : '0;
                QR_LEVEL:  rd_val = BUS_W'(lvl[dec.q]);
                QR_THRESH: rd_val = BUS_W'(thr[dec.q]);
                default:   rd_val = '0;
            endcase
        end
    end

    // Register read data; any read completes, unmatched ones with zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_en & ~bus_we;
            bus_rdata  <= rd ? rd_val : '0;
        end
    end
endmodule

// File: rtl/bidq_bank_chk.sv
// Temporal checks on the queue bank, bound into every bidq_bank instance.
module bidq_bank_chk
    import bidq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LW    = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_en,
    input logic                     bus_we,
    input logic                     bus_rvalid,
    input logic [NUM_Q-1:0][LW-1:0] lvl,
    input logic [NUM_Q-1:0][LW-1:0] thr,
    input logic [NUM_Q-1:0]         q_push,
    input logic [NUM_Q-1:0]         q_pop,
    input logic [NUM_Q-1:0]         hw_avail,
    input logic [NUM_Q-1:0]         status,
    input logic [NUM_Q-1:0]         ovf,
    input logic [NUM_Q-1:0]         mask,
    input logic [NUM_Q-1:0]         st_clr,
    input logic                     irq
);
    for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
        AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[g] <= LW'(DEPTH)); // R3
        AST_EMPTY_NO_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[g] == '0) |-> !hw_avail[g]); // R4
        AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[g] == LW'(DEPTH) && q_push[g] && !q_pop[g]) |=> (lvl[g] == LW'(DEPTH) && ovf[g])); // R5
        AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[g] > thr[g] && !st_clr[g]) |=> status[g]); // R6
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            st_clr[g] |=> !status[g]); // R7
    end

    AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & ~mask)))); // R8
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we) |=> bus_rvalid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> !bus_rvalid); // R2
endmodule

bind bidq_bank bidq_bank_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .lvl        (lvl),
    .thr        (thr),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .hw_avail   (hw_avail),
    .status     (status),
    .ovf        (ovf),
    .mask       (mask),
    .st_clr     (st_clr),
    .irq        (irq)
);

// File: tb/test_bidq_bank.sv
`timescale 1ns/1ps
module test_bidq_bank;
    localparam int         NQ     = 8;
    localparam int         IDW    = 13;
    localparam int         DEPTH  = 64;
    localparam logic [7:0] FILL   = 8'b0010_1101;  // R1: host-filled queues
    localparam logic [7:0] DRAIN  = 8'b1101_0010;  // R2: host-drained queues
    localparam logic [7:0] A_STAT = 8'h80;
    localparam logic [7:0] A_MASK = 8'h84;
    localparam logic [7:0] A_OVF  = 8'h88;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]          bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                bus_rvalid;
    logic [NQ-1:0]       hw_push_valid = '0;
    logic [NQ*IDW-1:0]   hw_push_id = '0;
    logic [NQ-1:0]       hw_pop_req = '0;
    logic [NQ-1:0]       hw_avail;
    logic [NQ*IDW-1:0]   hw_pop_id;
    logic                irq;

    always #2.5 clk = ~clk;

    bidq_bank i_bidq_bank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .hw_push_valid(hw_push_valid),
        .hw_push_id(hw_push_id), .hw_pop_req(hw_pop_req),
        .hw_avail(hw_avail), .hw_pop_id(hw_pop_id), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model: circular store per queue.
    logic [IDW-1:0] mm [NQ][DEPTH];
    int             mh [NQ];
    int             mc [NQ];
    logic [7:0]     movf = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        chk("R2 rvalid", {31'd0, bus_rvalid}, 32'd1);
    endtask

    task automatic hw_push(input int q, input logic [IDW-1:0] id);
        @(negedge clk);
        hw_push_valid[q] = 1'b1; hw_push_id[q*IDW +: IDW] = id;
        @(negedge clk);
        hw_push_valid[q] = 1'b0;
    endtask

    task automatic hw_pop(input int q, output logic [IDW-1:0] id, output logic av);
        @(negedge clk);
        av = hw_avail[q]; id = hw_pop_id[q*IDW +: IDW];
        hw_pop_req[q] = 1'b1;
        @(negedge clk);
        hw_pop_req[q] = 1'b0;
    endtask

    // Push through the queue's filling side and update the model.
    task automatic do_push(input int q, input logic [IDW-1:0] id);
        logic [31:0] junk;
        junk = $urandom;
        if (FILL[q]) cpu_write(8'(q << 4), {junk[31:IDW], id});  // R1 upper bits ignored
        else         hw_push(q, id);
        if (mc[q] < DEPTH) begin
            mm[q][(mh[q] + mc[q]) % DEPTH] = id;
            mc[q]++;
        end else movf[q] = 1'b1;
    endtask

    // Pop through the draining side and compare with the model.
    task automatic do_pop(input int q, input string req);
        logic [31:0]    got, exp;
        logic [IDW-1:0] hid;
        logic           av;
        exp = (mc[q] > 0) ? 32'(mm[q][mh[q]]) : 32'd0;
        if (DRAIN[q]) cpu_read(8'(q << 4), got);
        else begin
            hw_pop(q, hid, av);
            got = av ? 32'(hid) : 32'd0;
            chk({req, " R4 avail"}, {31'd0, av}, {31'd0, mc[q] > 0});
        end
        chk(req, got, exp);
        if (mc[q] > 0) begin
            mh[q] = (mh[q] + 1) % DEPTH;
            mc[q]--;
        end
    endtask

    task automatic chk_level(input int q, input string req);
        logic [31:0] v;
        cpu_read(8'((q << 4) | 4), v);
        chk(req, v, 32'(mc[q]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int q = 0; q < NQ; q++) begin mh[q] = 0; mc[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 irq", {31'd0, irq}, 32'd0);
        chk("R11 rvalid", {31'd0, bus_rvalid}, 32'd0);
        chk("R11 hw_avail", {24'd0, hw_avail}, 32'd0);
        for (int q = 0; q < NQ; q++) chk_level(q, "R11 level");
        cpu_read(A_STAT, v); chk("R11 status", v, 32'd0);
        cpu_read(A_OVF, v);  chk("R11 ovf", v, 32'd0);
        cpu_read(A_MASK, v); chk("R11 mask", v, 32'd0);
        cpu_read(8'h08, v);  chk("R11 threshold", v, 32'(DEPTH));

        // R1: host fills queue 0, hardware drains in order
        do_push(0, 13'h1ABC); do_push(0, 13'h0001); do_push(0, 13'h1FFF);
        chk_level(0, "R1 R3 level after host push");
        for (int i = 0; i < 3; i++) do_pop(0, "R1 hw pop order");
        chk_level(0, "R3 level after drain");

        // R2: hardware fills queue 1, host drains in order
        do_push(1, 13'h0555); do_push(1, 13'h1AAA); do_push(1, 13'h0800);
        chk_level(1, "R2 R3 level after hw push");
        for (int i = 0; i < 3; i++) do_pop(1, "R2 host pop order");

        // R4: pops from empty queues
        do_pop(1, "R4 host pop empty");
        do_pop(0, "R4 hw pop empty");
        chk_level(1, "R4 level stays zero");

        // R10: access against direction
        cpu_write(8'h10, 32'h0000_0123); chk_level(1, "R10 host write to hw-filled");
        hw_push(0, 13'h0777);            chk_level(0, "R10 hw push to host-filled");
        do_push(0, 13'h0321);
        cpu_read(8'h00, v); chk("R10 host read of hw-drained", v, 32'd0);
        chk_level(0, "R10 no pop on host read");
        chk("R10 hw head intact", 32'(hw_pop_id[0 +: IDW]), 32'h0321);

        // R9: wrong low address bits and unused slot
        cpu_write(8'h02, 32'h0000_0456); chk_level(0, "R9 misaligned write ignored");
        cpu_read(8'h05, v); chk("R9 misaligned read zero", v, 32'd0);
        cpu_read(8'h0C, v); chk("R9 unused slot zero", v, 32'd0);
        do_pop(0, "R9 queue content unchanged");

        // R6/R8: threshold crossing, status then interrupt one cycle later
        cpu_write(8'h28, 32'd2);
        do_push(2, 13'h0011); do_push(2, 13'h0022); do_push(2, 13'h0033);
        chk("R8 irq not yet (edge of push)", {31'd0, irq}, 32'd0);
        @(negedge clk); chk("R8 irq not yet (status edge)", {31'd0, irq}, 32'd0);
        @(negedge clk); chk("R8 irq raised", {31'd0, irq}, 32'd1);
        cpu_read(A_STAT, v); chk("R6 status set", v, 32'h04);

        // R7: clear wins for one edge, then re-set while still above
        cpu_write(A_STAT, 32'h04);
        chk("R7 irq before clear visible", {31'd0, irq}, 32'd1);
        @(negedge clk); chk("R7 irq drops after clear", {31'd0, irq}, 32'd0);
        @(negedge clk); chk("R7 irq returns after re-set", {31'd0, irq}, 32'd1);

        // R8: mask hides the bit, unmask restores it
        cpu_write(A_MASK, 32'h04);
        @(negedge clk); chk("R8 masked irq low", {31'd0, irq}, 32'd0);
        cpu_write(A_MASK, 32'h00);
        @(negedge clk); chk("R8 unmasked irq high", {31'd0, irq}, 32'd1);

        // R6: sticky after draining, R7 clear sticks once below
        for (int i = 0; i < 3; i++) do_pop(2, "R6 drain order");
        cpu_read(A_STAT, v); chk("R6 status sticky", v, 32'h04);
        cpu_write(A_STAT, 32'h04);
        @(negedge clk);
        cpu_read(A_STAT, v); chk("R7 status stays clear", v, 32'd0);
        @(negedge clk); chk("R8 irq low after clear", {31'd0, irq}, 32'd0);
        cpu_write(8'h28, 32'(DEPTH));

        // R5: fill queue 5 to DEPTH and overflow it
        for (int i = 0; i < DEPTH; i++) do_push(5, 13'(16'h0100 + i));
        do_push(5, 13'h1EEE);
        chk_level(5, "R5 level full");
        cpu_read(A_OVF, v); chk("R5 overflow bit", v, 32'h20);
        for (int i = 0; i < DEPTH; i++) do_pop(5, "R5 contents after drop");
        cpu_write(A_OVF, 32'h20); movf[5] = 1'b0;
        cpu_read(A_OVF, v); chk("R5 overflow cleared", v, 32'd0);

        // Random traffic across all queues against the model
        for (int i = 0; i < 600; i++) begin
            int q;
            q = int'($urandom % NQ);
            if ($urandom % 2) do_push(q, 13'($urandom));
            else              do_pop(q, "R1 R2 random pop");
        end
        for (int q = 0; q < NQ; q++) chk_level(q, "R3 random level");
        cpu_read(A_OVF, v); chk("R5 random overflow", v, 32'(movf));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule